// File: doc/BRIEF.md
# Two-Wire Bus Slave with Status Flags

This block is the slave side of a two-wire serial bus, with a clock line and an open-drain data line. Both lines pass through synchronizer flops. On the synchronized lines the block detects START and STOP conditions. It decodes a 7-bit address and its direction bit, and it answers either its own programmed address or, when enabled, the general call address. Bytes written by the master are collected into a receive holding register. Bytes read by the master are taken from a transmit holding register that software loads. The block drives the acknowledge bit for the address and for every received byte. It watches for the master's acknowledge after every transmitted byte.

Software sees a status word made of flags with different lifetimes. Some flags follow the bus by themselves: the access flag, the direction flag and the transmit-ready flag. Receive-ready is cleared by reading the receive holding register. The general call, overrun and not-acknowledged flags are cleared by a status read strobe. The data line is modelled as an output enable (`sda_oe` = 1 pulls the line low). The board or the bench resolves the wired-AND.

Top module: `tws_slave`

## Requirements
- R1: After reset, `sda_oe` is 0 and `status_o` reads 8'h02. The status bit layout is: bit0 receive-ready, bit1 transmit-ready, bit2 access, bit3 direction (1 = master reads), bit4 general call, bit5 overrun, bit6 not-acknowledged, bit7 zero.
- R2: After a START, the 8 bits are taken MSB first on SCL rising edges, as 7 address bits followed by the direction bit. If the address equals `own_addr`, the slave pulls SDA low in the ninth (acknowledge) slot and sets the access flag. The direction flag then copies the direction bit. Any other address gets no acknowledge and leaves the access flag at 0. The access flag rises only on an address match.
- R3: Address 7'h00 with direction 0 is acknowledged only when `gc_en` is 1. In that case it sets the general call flag, and a `sts_rd` pulse clears that flag.
- R4: During a write access, every data byte is shifted in MSB first and acknowledged, then copied to `rxh_data`, and receive-ready is set. A `rxh_rd` pulse clears receive-ready. Bytes sent while the slave is not addressed are neither acknowledged nor stored.
- R5: If a received byte is stored while receive-ready is already 1 and `rxh_rd` is not active in that cycle, the overrun flag is set, and `sts_rd` clears it. If the store and `rxh_rd` fall in the same cycle, the new byte is kept, receive-ready stays 1 and no overrun is flagged.
- R6: During a read access, the byte in the transmit holding register is sent MSB first, with SDA changed only while SCL is low. If the register is empty, 8'hFF is sent. Transmit-ready goes low in the cycle after `txh_wr` and returns high only once the byte loaded by that write has been sent and its acknowledge bit sampled.
- R7: A master not-acknowledge (SDA high in the ninth slot) after a transmitted byte sets the not-acknowledged flag and clears the access flag. No further byte is driven until a new START and address match. The flag is cleared by `sts_rd`.
- R8: A STOP condition clears the access flag and returns the slave to idle.
- R9: A repeated START does not clear the access flag. If the following address matches, the access flag stays set and the direction flag takes the new direction. If it does not match, the access flag clears.
- R10: `sda_oe` changes only in the cycle after a detected SCL falling edge, START or STOP. It is 0 outside the acknowledge slots the slave owns and the data bits it transmits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| own_addr | input | 7 | Programmed slave address |
| gc_en | input | 1 | Allow general call acknowledge |
| txh_wr | input | 1 | Load strobe for the transmit holding register |
| txh_data | input | 8 | Byte to transmit |
| rxh_rd | input | 1 | Read strobe for the receive holding register |
| rxh_data | output | 8 | Last byte received |
| sts_rd | input | 1 | Status read strobe (clears the read-clear flags) |
| status_o | output | 8 | Status flags, layout as in R1 |

## Verification
A byte can arrive from the bus in the very cycle in which software reads the receive holding register. The store and the read then meet on the receive-ready and overrun flags. The bench counts the synchronizer latency from the eighth SCL rise and places a one-cycle `rxh_rd` pulse in the cycle where the store happens. Receive-ready is judged to stay 1, overrun to stay 0, and `rxh_data` to hold the new byte. The same bench also provokes an actual overrun, so the two outcomes are compared side by side.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int ADDR_W = 7;
  localparam int DATA_W = ADDR_W + 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_RX,
    S_RACK,
    S_TX,
    S_TACK
  } tws_state_e;

  function automatic logic own_hit(input logic [ADDR_W-1:0] adr,
                                   input logic [ADDR_W-1:0] mine);
    return adr == mine;
  endfunction

  function automatic logic gc_hit(input logic [ADDR_W-1:0] adr,
                                  input logic rw, input logic en);
    return en && (adr == '0) && !rw;
  endfunction

  function automatic logic [7:0] pack_sts(input logic rx, input logic tx,
                                          input logic acc, input logic dir,
                                          input logic gc, input logic ovr,
                                          input logic nck);
    return {1'b0, nck, ovr, gc, dir, acc, tx, rx};
  endfunction

endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;
  logic scl_now, scl_prv, sda_prv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_now = scl_q[STAGES-1];
  assign scl_prv = scl_q[STAGES];
  assign sda_s   = sda_q[STAGES-1];
  assign sda_prv = sda_q[STAGES];

  assign scl_rise = scl_now && !scl_prv;
  assign scl_fall = !scl_now && scl_prv;
  assign start_ev = scl_now && scl_prv && !sda_s && sda_prv;
  assign stop_ev  = scl_now && scl_prv && sda_s && !sda_prv;

endmodule

// File: rtl/tws_flags.sv
module tws_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_load,
  input  logic rxh_rd,
  input  logic sts_rd,
  input  logic gc_set,
  input  logic nack_set,
  input  logic txh_wr,
  input  logic tx_acked,
  input  logic thr_empty,
  output logic rx_rdy,
  output logic tx_rdy,
  output logic gcall,
  output logic ovr,
  output logic nack
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_rdy <= 1'b0;
      tx_rdy <= 1'b1;
      gcall  <= 1'b0;
      ovr    <= 1'b0;
      nack   <= 1'b0;
    end else begin
      if (rx_load)     rx_rdy <= 1'b1;
      else if (rxh_rd) rx_rdy <= 1'b0;

      if (rx_load && rx_rdy && !rxh_rd) ovr <= 1'b1;
      else if (sts_rd)                  ovr <= 1'b0;

      if (gc_set)      gcall <= 1'b1;
      else if (sts_rd) gcall <= 1'b0;

      if (nack_set)    nack <= 1'b1;
      else if (sts_rd) nack <= 1'b0;

      if (txh_wr)                      tx_rdy <= 1'b0;
      else if (tx_acked && thr_empty)  tx_rdy <= 1'b1;
    end
  end

endmodule

// File: rtl/tws_slave.sv
module tws_slave
  import tws_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              gc_en,
  input  logic              txh_wr,
  input  logic [DATA_W-1:0] txh_data,
  input  logic              rxh_rd,
  output logic [DATA_W-1:0] rxh_data,
  input  logic              sts_rd,
  output logic [7:0]        status_o
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  tws_state_e        state;
  logic [1:0]        ph;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-2:0] shreg;
  logic [DATA_W-2:0] tsh;
  logic              acc, rd_dir;
  logic [DATA_W-1:0] thr;
  logic              thr_full, tx_pend;

  // named internal events
  logic [DATA_W-1:0] in_word;
  logic              hit_own, hit_gc, addr_done;
  logic              rx_load, gc_set, tack_sample, nack_set, tx_acked, tx_load;
  logic [DATA_W-1:0] tx_byte;
  logic              rx_rdy, tx_rdy, gcall, ovr, nack;

  assign in_word     = {shreg, sda_s};
  assign hit_own     = own_hit(in_word[DATA_W-1:1], own_addr);
  assign hit_gc      = gc_hit(in_word[DATA_W-1:1], in_word[0], gc_en);
  assign addr_done   = (state == S_ADDR) && scl_rise && (cnt == LAST);
  assign gc_set      = addr_done && hit_gc;
  assign rx_load     = (state == S_RX) && scl_rise && (cnt == LAST);
  assign tack_sample = (state == S_TACK) && (ph == 2'd1) && scl_rise;
  assign nack_set    = tack_sample && sda_s;
  assign tx_acked    = tack_sample && tx_pend;
  assign tx_load     = scl_fall &&
                       (((state == S_AACK) && (ph == 2'd1) && rd_dir) ||
                        ((state == S_TACK) && (ph == 2'd2)));
  assign tx_byte     = thr_full ? thr : '1;

  // transmit holding register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr      <= '0;
      thr_full <= 1'b0;
      tx_pend  <= 1'b0;
    end else begin
      if (tx_load) begin
        thr_full <= 1'b0;
        tx_pend  <= thr_full;
      end
      if (txh_wr) begin
        thr      <= txh_data;
        thr_full <= 1'b1;
      end
    end
  end

  // bus sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      ph       <= '0;
      cnt      <= '0;
      shreg    <= '0;
      tsh      <= '0;
      sda_oe   <= 1'b0;
      acc      <= 1'b0;
      rd_dir   <= 1'b0;
      rxh_data <= '0;
    end else if (stop_ev) begin
      state  <= S_IDLE;
      acc    <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_ev) begin
      state  <= S_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        S_ADDR: if (scl_rise) begin
          shreg <= in_word[DATA_W-2:0];
          cnt   <= cnt + 1'b1;
          if (cnt == LAST) begin
            cnt <= '0;
            if (hit_own || hit_gc) begin
              acc    <= 1'b1;
              rd_dir <= in_word[0];
              state  <= S_AACK;
              ph     <= 2'd0;
            end else begin
              acc   <= 1'b0;
              state <= S_IDLE;
            end
          end
        end
        S_AACK, S_RACK: if (scl_fall) begin
          if (ph == 2'd0) begin
            sda_oe <= 1'b1;
            ph     <= 2'd1;
          end else begin
            cnt <= '0;
            if (tx_load) begin
              state  <= S_TX;
              sda_oe <= ~tx_byte[DATA_W-1];
              tsh    <= tx_byte[DATA_W-2:0];
            end else begin
              state  <= S_RX;
              sda_oe <= 1'b0;
            end
          end
        end
        S_RX: if (scl_rise) begin
          shreg <= in_word[DATA_W-2:0];
          cnt   <= cnt + 1'b1;
          if (rx_load) begin
            rxh_data <= in_word;
            cnt      <= '0;
            state    <= S_RACK;
            ph       <= 2'd0;
          end
        end
        S_TX: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              cnt   <= '0;
              state <= S_TACK;
              ph    <= 2'd0;
            end
          end else if (scl_fall) begin
            sda_oe <= ~tsh[DATA_W-2];
            tsh    <= {tsh[DATA_W-3:0], 1'b0};
          end
        end
        S_TACK: begin
          if ((ph == 2'd0) && scl_fall) begin
            sda_oe <= 1'b0;
            ph     <= 2'd1;
          end else if (tack_sample) begin
            if (nack_set) begin
              acc   <= 1'b0;
              state <= S_IDLE;
            end else begin
              ph <= 2'd2;
            end
          end else if (tx_load) begin
            state  <= S_TX;
            cnt    <= '0;
            sda_oe <= ~tx_byte[DATA_W-1];
            tsh    <= tx_byte[DATA_W-2:0];
          end
        end
        default: ;
      endcase
    end
  end

  tws_flags u_flags (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rxh_rd(rxh_rd),
    .sts_rd(sts_rd), .gc_set(gc_set), .nack_set(nack_set),
    .txh_wr(txh_wr), .tx_acked(tx_acked), .thr_empty(!thr_full),
    .rx_rdy(rx_rdy), .tx_rdy(tx_rdy), .gcall(gcall), .ovr(ovr), .nack(nack)
  );

  assign status_o = pack_sts(rx_rdy, tx_rdy, acc, rd_dir, gcall, ovr, nack);

endmodule

// File: rtl/tws_slave_chk.sv
module tws_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev,
  input logic addr_done,
  input logic rx_load,
  input logic rxh_rd,
  input logic sts_rd,
  input logic gc_set,
  input logic nack_set,
  input logic txh_wr,
  input logic acc,
  input logic rx_rdy,
  input logic tx_rdy,
  input logic gcall,
  input logic ovr,
  input logic nack
);

  p_acc_from_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc) |-> $past(addr_done));

  p_gc_read_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && !gc_set) |=> !gcall);

  p_rx_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rx_rdy);

  p_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_load && rx_rdy && !rxh_rd) |=> ovr);

  p_txrdy_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    txh_wr |=> !tx_rdy);

  p_nack_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nack_set |=> (!acc && nack));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !acc);

  p_restart_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && acc) |=> acc);

  p_oe_timing_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

endmodule

bind tws_slave tws_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .addr_done(addr_done),
  .rx_load(rx_load), .rxh_rd(rxh_rd), .sts_rd(sts_rd), .gc_set(gc_set),
  .nack_set(nack_set), .txh_wr(txh_wr), .acc(acc), .rx_rdy(rx_rdy),
  .tx_rdy(tx_rdy), .gcall(gcall), .ovr(ovr), .nack(nack)
);

// File: tb/test_tws_slave.sv
module test_tws_slave;

  localparam int H = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic gc_en = 1'b0, txh_wr = 1'b0, rxh_rd = 1'b0, sts_rd = 1'b0;
  logic [7:0] txh_data = '0;
  logic [7:0] rxh_data, status_o;
  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  tws_slave i_tws_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .own_addr(OWN), .gc_en(gc_en), .txh_wr(txh_wr),
    .txh_data(txh_data), .rxh_rd(rxh_rd), .rxh_data(rxh_data),
    .sts_rd(sts_rd), .status_o(status_o)
  );

  // rows: {address, gc_en, data, expect_ack}
  localparam logic [16:0] VEC [0:6] = '{
    {7'h5A, 1'b0, 8'hA5, 1'b1},
    {7'h5B, 1'b0, 8'h3C, 1'b0},
    {7'h00, 1'b1, 8'h0F, 1'b1},
    {7'h00, 1'b0, 8'hF0, 1'b0},
    {7'h1A, 1'b0, 8'h81, 1'b0},
    {7'h5A, 1'b1, 8'h00, 1'b1},
    {7'h5A, 1'b0, 8'hFF, 1'b1}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; waitn(H);
    scl_m = 1'b1; waitn(H);
    sda_m = 1'b0; waitn(H);
    scl_m = 1'b0; waitn(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; waitn(H);
    scl_m = 1'b1; waitn(H);
    sda_m = 1'b1; waitn(H);
  endtask

  task automatic wbit(input logic b, input bit coinc);
    sda_m = b; waitn(H);
    scl_m = 1'b1;
    if (coinc) begin
      waitn(2); rxh_rd = 1'b1; waitn(1); rxh_rd = 1'b0; waitn(H - 3);
    end else waitn(H);
    scl_m = 1'b0; waitn(1);
  endtask

  task automatic rbit(output logic b, output logic oe_hit);
    sda_m = 1'b1; waitn(H);
    scl_m = 1'b1; waitn(3);
    b = sda_line; oe_hit = sda_oe;
    waitn(3);
    scl_m = 1'b0; waitn(1);
  endtask

  task automatic wr_byte(input logic [7:0] d, input bit coinc, output logic ack);
    logic oe_hit;
    for (int i = 7; i >= 0; i--) wbit(d[i], coinc && (i == 0));
    rbit(ack, oe_hit);
    ack = ~ack;
  endtask

  task automatic rd_byte(output logic [7:0] d, output logic any_oe);
    logic b, o;
    any_oe = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      rbit(b, o); d[i] = b; any_oe = any_oe | o;
    end
  endtask

  task automatic pulse_rxrd(); rxh_rd = 1'b1; waitn(1); rxh_rd = 1'b0; waitn(1); endtask
  task automatic pulse_sts();  sts_rd = 1'b1; waitn(1); sts_rd = 1'b0; waitn(1); endtask
  task automatic load_thr(input logic [7:0] d);
    txh_data = d; txh_wr = 1'b1; waitn(1); txh_wr = 1'b0; waitn(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic ack, anyoe;
    logic [7:0] got;
    waitn(4);
    rst_n = 1'b1;
    waitn(4);
    // R1 reset state
    chk("R1", "status after reset", status_o, 8'h02);
    chk("R1", "sda_oe after reset", sda_oe, 1'b0);

    // table-driven write transfers (R2 R3 R4 R8)
    foreach (VEC[k]) begin
      logic [6:0] a; logic ge; logic [7:0] d; logic ex;
      {a, ge, d, ex} = VEC[k];
      gc_en = ge;
      bus_start();
      wr_byte({a, 1'b0}, 1'b0, ack);
      chk(a == 7'h0 ? "R3" : "R2", "address ack", ack, ex);
      chk("R2", "access flag", status_o[2], ex);
      if (ex) begin
        chk("R2", "direction flag write", status_o[3], 1'b0);
        chk("R3", "general call flag", status_o[4], a == 7'h00 && a != OWN);
      end
      wr_byte(d, 1'b0, ack);
      chk("R4", "data ack", ack, ex);
      chk("R4", "receive ready", status_o[0], ex);
      if (ex) begin
        chk("R4", "received byte", rxh_data, d);
        pulse_rxrd();
        chk("R4", "receive ready cleared", status_o[0], 1'b0);
      end
      bus_stop();
      chk("R8", "access after stop", status_o[2], 1'b0);
      chk("R10", "sda released after stop", sda_oe, 1'b0);
      if (ex && a == 7'h00) begin
        pulse_sts();
        chk("R3", "general call cleared by read", status_o[4], 1'b0);
      end
    end
    gc_en = 1'b0;

    // R6 read transfer and transmit-ready lifetime
    load_thr(8'hC3);
    chk("R6", "tx ready low after write", status_o[1], 1'b0);
    bus_start();
    wr_byte({OWN, 1'b1}, 1'b0, ack);
    chk("R2", "read address ack", ack, 1'b1);
    chk("R2", "direction flag read", status_o[3], 1'b1);
    rd_byte(got, anyoe);
    chk("R6", "first read byte", got, 8'hC3);
    chk("R6", "tx ready low before ack", status_o[1], 1'b0);
    load_thr(8'h96);
    wbit(1'b0, 1'b0);
    chk("R6", "tx ready low with new byte queued", status_o[1], 1'b0);
    rd_byte(got, anyoe);
    chk("R6", "second read byte", got, 8'h96);
    wbit(1'b1, 1'b0);
    chk("R7", "nack flag", status_o[6], 1'b1);
    chk("R7", "access cleared by nack", status_o[2], 1'b0);
    chk("R6", "tx ready high after nack", status_o[1], 1'b1);
    // R7 byte loaded after nack must not be sent
    load_thr(8'h00);
    rd_byte(got, anyoe);
    chk("R7", "no byte after nack", got, 8'hFF);
    chk("R7", "slave silent after nack", anyoe, 1'b0);
    bus_stop();
    chk("R7", "queued byte still pending", status_o[1], 1'b0);
    pulse_sts();
    chk("R7", "nack cleared by status read", status_o[6], 1'b0);

    // R5 overrun and coincident store/read
    bus_start();
    wr_byte({OWN, 1'b0}, 1'b0, ack);
    wr_byte(8'h11, 1'b0, ack);
    wr_byte(8'h22, 1'b0, ack);
    chk("R5", "overrun set", status_o[5], 1'b1);
    chk("R5", "latest byte kept", rxh_data, 8'h22);
    pulse_sts();
    chk("R5", "overrun cleared", status_o[5], 1'b0);
    wr_byte(8'h33, 1'b1, ack);
    chk("R5", "coincident: rx ready stays", status_o[0], 1'b1);
    chk("R5", "coincident: no overrun", status_o[5], 1'b0);
    chk("R5", "coincident: new byte", rxh_data, 8'h33);
    pulse_rxrd();

    // R9 repeated start with match then read
    bus_start();
    wr_byte({OWN, 1'b1}, 1'b0, ack);
    chk("R9", "restart address ack", ack, 1'b1);
    chk("R9", "access held over restart", status_o[2], 1'b1);
    chk("R9", "direction updated", status_o[3], 1'b1);
    rd_byte(got, anyoe);
    chk("R6", "queued byte sent in later access", got, 8'h00);
    wbit(1'b1, 1'b0);
    chk("R6", "tx ready after queued byte", status_o[1], 1'b1);
    pulse_sts();
    // R9 repeated start with mismatch
    bus_start();
    wr_byte({OWN, 1'b0}, 1'b0, ack);
    chk("R9", "access before restart", status_o[2], 1'b1);
    bus_start();
    wr_byte({7'h33, 1'b0}, 1'b0, ack);
    chk("R9", "mismatch not acked", ack, 1'b0);
    chk("R9", "access cleared by mismatch", status_o[2], 1'b0);
    bus_stop();
    chk("R10", "sda released at end", sda_oe, 1'b0);

    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule